// File: doc/BRIEF.md
# Double-Rate Word Capture and Crossing Framer

This block takes the parallel data lines of one source, which arrive at double data rate alongside the source's own forwarded clock. It groups each run of four consecutive transfers into a single wide word that covers one beam crossing. The capture clock `clk` is modelled at the transfer rate, so every rising edge of `clk` stands for one data-rate sample. That is one sample on each edge of the forwarded clock, taken at the centre of the bit period.

When the block comes out of reset it does not know which transfer opens a crossing. The source therefore sends a reserved training word for a few crossings after startup, and normal physics traffic can never produce that word. The block watches a rolling window of the last four transfers and counts how many times in a row the training word lines up at each of the four possible offsets. When one offset reaches the lock count, the block locks onto it and keeps that framing until `resync` is asserted. While locked, it delivers one framed word per crossing together with a single-cycle strobe. A training word that arrives after lock is flagged and is never marked as valid data.

Top module: `ddr_crossing_framer`

## Requirements
- R1: While reset is applied, and in the first cycle after it is released, `locked`, `word_valid` and `train_seen` are all low.
- R2: A framed word holds its first transfer in bits [23:0], the second in [47:24], the third in [71:48] and the fourth in [95:72]. With default parameters the word leaves the block in order, one word per crossing.
- R3: Lock needs LOCK_COUNT (default 2) consecutive training words at the same offset. A single training crossing followed by other data leaves `locked` low and produces no `word_valid`.
- R4: The framer locks correctly whichever of the four transfer offsets the training sequence starts on, counted from reset. The default training word is 96'h69E1B7_0F9652_A5F03C_C35AD2.
- R5: Once locked, the frame offset stays the same until `resync`. If a single extra transfer is inserted, the words after it are still framed at the old offset.
- R6: `word_valid` is a one-cycle pulse. It is high only while `locked` is high and never in two consecutive cycles.
- R7: A training word framed while locked raises `train_seen` for one cycle and does not raise `word_valid`.
- R8: A cycle with `resync` high clears `locked` on the next edge, and the search starts again. A new training sequence at a different offset then locks, and the words that follow are framed at the new offset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Capture clock, one edge per double-rate transfer |
| rst_n | input | 1 | Active-low synchronous reset |
| resync | input | 1 | Drops lock and restarts the training search |
| xfer_in | input | 24 | One transfer of data lines |
| locked | output | 1 | Crossing offset has been found |
| word_out | output | 96 | Most recent framed crossing word |
| word_valid | output | 1 | One-cycle strobe for a physics word on `word_out` |
| train_seen | output | 1 | One-cycle flag for a training word framed while locked |

## Verification
The embedded properties check on every clock the relationships that hold regardless of data content. These are: valid strobes are isolated and occur only under lock, a training flag occurs only under lock, the offset is frozen while locked, `resync` clears lock, and lock rises only after a pattern hit. Whether the right offset was chosen, and whether the packed bits land in the right lanes, depends on the data stream. Only the directed scenarios can show this. They compare framed words against crossings built in the bench, after training at each of the four offsets, after a one-transfer slip, after a short training sequence and after a resync.

// File: rtl/framer_pkg.sv
package framer_pkg;
    localparam int unsigned DEF_XFER_W     = 24;
    localparam int unsigned DEF_LANES      = 4;
    localparam int unsigned DEF_LOCK_COUNT = 2;
    localparam logic [DEF_XFER_W*DEF_LANES-1:0] DEF_PATTERN =
        96'h69E1B7_0F9652_A5F03C_C35AD2;
endpackage

// File: rtl/xfer_history.sv
module xfer_history #(
    parameter int unsigned XFER_W = 24,
    parameter int unsigned LANES  = 4,
    localparam int unsigned WORD_W = XFER_W * LANES,
    localparam int unsigned SLOT_W = $clog2(LANES)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [XFER_W-1:0] xfer_in,
    output logic [WORD_W-1:0] hist,
    output logic [SLOT_W-1:0] slot
);
    localparam logic [SLOT_W-1:0] SLOT_LAST = SLOT_W'(LANES - 1);

    typedef struct packed {
        logic [WORD_W-1:0] hist;
        logic [SLOT_W-1:0] slot;
    } hist_t;

    hist_t s_d, s_q;

    always_comb begin
        s_d      = s_q;
        // newest transfer enters at the top, oldest sits in the low lane
        s_d.hist = {xfer_in, s_q.hist[WORD_W-1:XFER_W]};
        s_d.slot = (s_q.slot == SLOT_LAST) ? '0 : s_q.slot + 1'b1;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    assign hist = s_q.hist;
    assign slot = s_q.slot;
endmodule

// File: rtl/phase_hunter.sv
module phase_hunter #(
    parameter int unsigned XFER_W     = 24,
    parameter int unsigned LANES      = 4,
    parameter int unsigned LOCK_COUNT = 2,
    localparam int unsigned WORD_W = XFER_W * LANES,
    localparam int unsigned SLOT_W = $clog2(LANES),
    localparam int unsigned CNT_W  = $clog2(LOCK_COUNT + 1),
    parameter logic [WORD_W-1:0] PATTERN = '1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              resync,
    input  logic [WORD_W-1:0] hist,
    input  logic [SLOT_W-1:0] slot,
    output logic              hit,
    output logic              locked,
    output logic [SLOT_W-1:0] phase
);
    typedef struct packed {
        logic                         locked;
        logic [SLOT_W-1:0]            phase;
        logic [LANES-1:0][CNT_W-1:0]  streak;
    } hunt_t;

    hunt_t s_d, s_q;

    logic [LANES-1:0]             probe;
    logic [LANES-1:0]             reach;
    logic [LANES-1:0][CNT_W-1:0]  streak_inc;

    assign hit = (hist == PATTERN);

    for (genvar p = 0; p < LANES; p++) begin : g_offset
        assign probe[p]      = !s_q.locked && (slot == SLOT_W'(p));
        assign streak_inc[p] = s_q.streak[p] + 1'b1;
        assign reach[p]      = probe[p] && hit &&
                               (streak_inc[p] == CNT_W'(LOCK_COUNT));
    end

    always_comb begin
        s_d = s_q;
        if (resync) begin
            s_d = '0;
        end else if (!s_q.locked) begin
            for (int p = 0; p < LANES; p++) begin
                if (probe[p]) s_d.streak[p] = hit ? streak_inc[p] : '0;
                if (reach[p]) begin
                    s_d.locked = 1'b1;
                    s_d.phase  = SLOT_W'(p);
                end
            end
            if (|reach) s_d.streak = '0;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    assign locked = s_q.locked;
    assign phase  = s_q.phase;

    // R5
    phase_frozen_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (s_q.locked && !resync) |=> (s_q.locked && $stable(s_q.phase)));
    // R8
    resync_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        resync |=> !s_q.locked);
    // R3
    lock_after_hit_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(s_q.locked) |-> $past(hit));
endmodule

// File: rtl/word_emitter.sv
module word_emitter #(
    parameter int unsigned XFER_W = 24,
    parameter int unsigned LANES  = 4,
    localparam int unsigned WORD_W = XFER_W * LANES,
    localparam int unsigned SLOT_W = $clog2(LANES)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              resync,
    input  logic [WORD_W-1:0] hist,
    input  logic [SLOT_W-1:0] slot,
    input  logic [SLOT_W-1:0] phase,
    input  logic              locked,
    input  logic              hit,
    output logic [WORD_W-1:0] word_out,
    output logic              word_valid,
    output logic              train_seen
);
    typedef struct packed {
        logic [WORD_W-1:0] word;
        logic              valid;
        logic              train;
    } emit_t;

    emit_t s_d, s_q;
    logic  boundary;

    assign boundary = locked && !resync && (slot == phase);

    always_comb begin
        s_d       = s_q;
        s_d.valid = boundary && !hit;
        s_d.train = boundary && hit;
        if (boundary) s_d.word = hist;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    assign word_out   = s_q.word;
    assign word_valid = s_q.valid;
    assign train_seen = s_q.train;

    // R6
    single_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        s_q.valid |=> !s_q.valid);
    // R6
    valid_needs_lock_chk: assert property (@(posedge clk) disable iff (!rst_n)
        s_q.valid |-> locked);
    // R7
    train_needs_lock_chk: assert property (@(posedge clk) disable iff (!rst_n)
        s_q.train |-> (locked && !s_q.valid));
endmodule

// File: rtl/ddr_crossing_framer.sv
module ddr_crossing_framer
    import framer_pkg::*;
#(
    parameter int unsigned XFER_W     = DEF_XFER_W,
    parameter int unsigned LANES      = DEF_LANES,
    parameter int unsigned LOCK_COUNT = DEF_LOCK_COUNT,
    localparam int unsigned WORD_W = XFER_W * LANES,
    localparam int unsigned SLOT_W = $clog2(LANES),
    parameter logic [WORD_W-1:0] PATTERN = DEF_PATTERN
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              resync,
    input  logic [XFER_W-1:0] xfer_in,
    output logic              locked,
    output logic [WORD_W-1:0] word_out,
    output logic              word_valid,
    output logic              train_seen
);
    logic [WORD_W-1:0] hist;
    logic [SLOT_W-1:0] slot;
    logic [SLOT_W-1:0] phase;
    logic              hit;

    xfer_history #(.XFER_W(XFER_W), .LANES(LANES)) i_history (
        .clk     (clk),
        .rst_n   (rst_n),
        .xfer_in (xfer_in),
        .hist    (hist),
        .slot    (slot)
    );

    phase_hunter #(
        .XFER_W     (XFER_W),
        .LANES      (LANES),
        .LOCK_COUNT (LOCK_COUNT),
        .PATTERN    (PATTERN)
    ) i_hunter (
        .clk    (clk),
        .rst_n  (rst_n),
        .resync (resync),
        .hist   (hist),
        .slot   (slot),
        .hit    (hit),
        .locked (locked),
        .phase  (phase)
    );

    word_emitter #(.XFER_W(XFER_W), .LANES(LANES)) i_emitter (
        .clk        (clk),
        .rst_n      (rst_n),
        .resync     (resync),
        .hist       (hist),
        .slot       (slot),
        .phase      (phase),
        .locked     (locked),
        .hit        (hit),
        .word_out   (word_out),
        .word_valid (word_valid),
        .train_seen (train_seen)
    );
endmodule

// File: tb/test_ddr_crossing_framer.sv
`timescale 1ns/1ps
module test_ddr_crossing_framer;
    localparam logic [95:0] TRAIN = 96'h69E1B7_0F9652_A5F03C_C35AD2;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        resync = 1'b0;
    logic [23:0] xfer_in = '0;
    logic        locked;
    logic [95:0] word_out;
    logic        word_valid;
    logic        train_seen;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    logic [95:0] vwords [0:15];
    int          vcount = 0;
    int          tcount = 0;
    logic        prev_valid = 1'b0;

    always #2.5 clk = ~clk;

    ddr_crossing_framer i_ddr_crossing_framer (
        .clk        (clk),
        .rst_n      (rst_n),
        .resync     (resync),
        .xfer_in    (xfer_in),
        .locked     (locked),
        .word_out   (word_out),
        .word_valid (word_valid),
        .train_seen (train_seen)
    );

    task automatic check(input bit ok, input string req, input logic [95:0] act,
                         input logic [95:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // monitor samples away from the active edge
    always @(negedge clk) begin
        if (rst_n) begin
            if (word_valid) begin
                if (vcount < 16) vwords[vcount] = word_out;
                vcount++;
                // R6: valid only under lock, never back to back
                check(locked && !prev_valid, "R6", {94'd0, prev_valid, locked}, 96'd1);
            end
            if (train_seen) tcount++;
            prev_valid = word_valid;
        end
    end

    function automatic logic [95:0] phys(input int k);
        logic [95:0] w;
        for (int j = 0; j < 4; j++)
            w[j*24 +: 24] = 24'((k + 1) * 24'h010203 + j * 24'h111111);
        return w;
    endfunction

    task automatic send_xfer(input logic [23:0] d);
        @(negedge clk);
        xfer_in = d;
    endtask

    task automatic send_word(input logic [95:0] w);
        for (int j = 0; j < 4; j++) send_xfer(w[j*24 +: 24]);
    endtask

    task automatic flush();
        for (int j = 0; j < 8; j++) send_xfer(24'd0);
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0; resync = 1'b0; xfer_in = '0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        vcount = 0; tcount = 0; prev_valid = 1'b0;
    endtask

    task automatic test_reset();
        @(negedge clk);
        rst_n = 1'b0;
        @(negedge clk);
        // R1
        check(!locked && !word_valid && !train_seen, "R1 in reset",
              {93'd0, locked, word_valid, train_seen}, 96'd0);
        do_reset();
        @(negedge clk);
        check(!locked && !word_valid && !train_seen, "R1 after release",
              {93'd0, locked, word_valid, train_seen}, 96'd0);
    endtask

    task automatic test_offset(input int off);
        do_reset();
        for (int j = 0; j < off; j++) send_xfer(24'h000000);
        for (int j = 0; j < 3; j++) send_word(TRAIN);
        // R4
        check(locked, "R4 lock at offset", {95'd0, locked}, 96'd1);
        vcount = 0;
        for (int k = 0; k < 3; k++) send_word(phys(k + off * 10));
        flush();
        check(vcount >= 3, "R2 word count", 96'(vcount), 96'd3);
        for (int k = 0; k < 3; k++)
            check(vwords[k] == phys(k + off * 10), "R2 packing", vwords[k], phys(k + off * 10));
        // R7
        check(tcount == 1, "R7 training flagged", 96'(tcount), 96'd1);
    endtask

    task automatic test_short_training();
        do_reset();
        send_xfer(24'h000000);
        send_word(TRAIN);
        for (int k = 0; k < 2; k++) send_word(phys(k + 50));
        flush();
        // R3
        check(!locked, "R3 no lock on one crossing", {95'd0, locked}, 96'd0);
        check(vcount == 0, "R3 no valid output", 96'(vcount), 96'd0);
    endtask

    task automatic test_slip();
        logic [95:0] p0, p1, e0, e1;
        p0 = phys(60); p1 = phys(61);
        do_reset();
        send_xfer(24'h000000);
        for (int j = 0; j < 3; j++) send_word(TRAIN);
        vcount = 0;
        send_xfer(24'hABCDEF);
        send_word(p0);
        send_word(p1);
        flush();
        e0 = {p0[71:0], 24'hABCDEF};
        e1 = {p1[71:0], p0[95:72]};
        // R5
        check(locked, "R5 still locked", {95'd0, locked}, 96'd1);
        check(vwords[0] == e0, "R5 old offset word0", vwords[0], e0);
        check(vwords[1] == e1, "R5 old offset word1", vwords[1], e1);
    endtask

    task automatic test_resync();
        do_reset();
        for (int j = 0; j < 3; j++) send_word(TRAIN);
        check(locked, "R8 initial lock", {95'd0, locked}, 96'd1);
        @(negedge clk);
        resync = 1'b1; xfer_in = '0;
        @(negedge clk);
        resync = 1'b0;
        // R8
        check(!locked, "R8 lock cleared", {95'd0, locked}, 96'd0);
        send_xfer(24'h000000);
        for (int j = 0; j < 3; j++) send_word(TRAIN);
        check(locked, "R8 relock", {95'd0, locked}, 96'd1);
        vcount = 0;
        send_word(phys(70));
        send_word(phys(71));
        flush();
        check(vwords[0] == phys(70), "R8 new offset word0", vwords[0], phys(70));
        check(vwords[1] == phys(71), "R8 new offset word1", vwords[1], phys(71));
    endtask

    initial begin
        test_reset();
        for (int off = 0; off < 4; off++) test_offset(off);
        test_short_training();
        test_slip();
        test_resync();
        if (!done) begin
            done = 1'b1;
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

    initial begin
        #(100000 * 5);
        if (!done) begin
            done = 1'b1;
            checks++; fails++;
            $display("FAIL watchdog actual=timeout expected=completion");
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end
endmodule